// File: doc/BRIEF.md
# Dual-Host Port Selection Controller

This block is the digital control core of a three-port serial-link selector. Two host ports (0 and 1) share a single device port (2). The block chooses which host's receive data feeds the device-port transmitter. It also decides whether the unselected host's transmitter is switched off or repeats the device data. Every transmitter is parked at its common-mode level while its source input is in out-of-band idle.

Selection follows one of two modes. In level mode, select line 0 names the host directly. In edge mode, a rising edge on a select line claims the device port for the matching host, and that choice is held until the next accepted edge. All control inputs are synchronized into the block clock before use. After power-up, the first selection is decoded from both select lines.

Two status outputs are provided. One reports the selected host in edge mode and the idle flag of host 1 in level mode. The other always mirrors the idle flag of host 0.

Top module: `host_sel_ctrl`

## Requirements
- R1: In level mode (edge_mode_i low) with sel1_i low, dev_src_o follows sel0_i (0 = host 0, 1 = host 1), and a change appears on the third rising clock edge after the input changes.
- R2: In level mode, while sel1_i is high, dev_src_o holds its value whatever sel0_i does.
- R3: In edge mode, a rising edge on sel0_i sets dev_src_o to 0 and a rising edge on sel1_i sets it to 1, on the third clock edge after the input rises. Falling edges and steady levels leave the selection unchanged.
- R4: When rising edges on both select lines are seen in the same cycle, host 0 is selected.
- R5: After any accepted edge, and after the power-up load, rising edges detected during the next GAP_CYCLES cycles (default 4) are ignored.
- R6: Three clock edges after reset is released, the selection is loaded. In edge mode, the select pair (sel0_i, sel1_i) = (0,1) gives host 1 and every other pair gives host 0. In level mode, sel0_i is loaded. While reset is held, dev_src_o is 0.
- R7: Switching from level to edge mode keeps the current selection. Switching from edge to level mode adopts sel0_i.
- R8: oe_o bit 2 (device transmitter) is high exactly when the selected host's idle flag is low. The selected host's enable (oe_o bit 0 or 1) is high exactly when idle_i bit 2 is low.
- R9: The unselected host's enable is low when mirror_i is low. When mirror_i is high, it equals the inverse of idle_i bit 2.
- R10: In edge mode, sel_stat_o is 1 when host 0 is selected and 0 when host 1 is selected. In level mode, it equals idle_i bit 1.
- R11: idle0_o always equals idle_i bit 0, where 1 means below the signal threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| edge_mode_i | input | 1 | 0 = level select, 1 = rising-edge select |
| mirror_i | input | 1 | 1 = unselected host transmitter repeats device data |
| sel0_i | input | 1 | Select line 0 |
| sel1_i | input | 1 | Select line 1 |
| idle_i | input | 3 | Out-of-band idle flags of the receivers: bit 0 host 0, bit 1 host 1, bit 2 device |
| dev_src_o | output | 1 | Source of the device transmitter: 0 = host 0, 1 = host 1 |
| oe_o | output | 3 | Transmitter enables: bit 0 host 0, bit 1 host 1, bit 2 device |
| sel_stat_o | output | 1 | Selected host (edge mode) or host 1 idle flag (level mode) |
| idle0_o | output | 1 | Host 0 idle flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the rising edges of both select lines. The bench raises both lines between one pair of clock edges and expects host 0 three edges later. The second pair is a new rising edge and a still-running guard window. The bench raises the opposite line two cycles after an accepted switch and expects the selection to stay put. It then expects the same edge, repeated after the window expires, to take effect.

// File: rtl/host_sel_pkg.sv
package host_sel_pkg;
  localparam int HOSTS   = 2;
  localparam int PORTS   = 3;
  localparam int DEV_IDX = 2;
  localparam int CTRL_W  = 4;
  localparam int C_SEL0  = 0;
  localparam int C_SEL1  = 1;
  localparam int C_MIRR  = 2;
  localparam int C_EDGE  = 3;

  typedef enum logic { HOST0 = 1'b0, HOST1 = 1'b1 } host_e;
  typedef enum logic { PH_FILL = 1'b0, PH_RUN = 1'b1 } phase_e;

  // edge-mode power-up: only (0,1) picks host 1
  function automatic host_e powerup_pick(logic s0, logic s1);
    return (s1 && !s0) ? HOST1 : HOST0;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_select.sv
module hs_select
  import host_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  edge_mode_i,
  input  logic  sel0_i,
  input  logic  sel1_i,
  output host_e sel_o
);
  localparam int FW = $clog2(SYNC_STAGES + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [FW-1:0] FILL_LAST = FW'(SYNC_STAGES);
  localparam logic [GW-1:0] GAP_LOAD  = GW'(GAP_CYCLES);

  phase_e          phase_q, phase_d;
  logic [FW-1:0]   fill_q;
  logic            prev0_q, prev1_q;
  logic            rise0, rise1;
  logic [GW-1:0]   guard_q, guard_d;
  host_e           sel_q, sel_d;

  always_comb begin
    rise0   = sel0_i & ~prev0_q;
    rise1   = sel1_i & ~prev1_q;
    sel_d   = sel_q;
    phase_d = phase_q;
    guard_d = (guard_q == '0) ? '0 : guard_q - GW'(1);
    if (phase_q == PH_FILL) begin
      // wait until the synchronizer holds real input values
      if (fill_q == FILL_LAST) begin
        phase_d = PH_RUN;
        guard_d = GAP_LOAD;
        if (edge_mode_i)  sel_d = powerup_pick(sel0_i, sel1_i);
        else if (!sel1_i) sel_d = host_e'(sel0_i);
      end
    end else if (edge_mode_i) begin
      if (guard_q == '0 && (rise0 || rise1)) begin
        sel_d   = rise0 ? HOST0 : HOST1;  // host 0 wins a tie
        guard_d = GAP_LOAD;
      end
    end else if (!sel1_i) begin
      sel_d = host_e'(sel0_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FILL;
      fill_q  <= '0;
      prev0_q <= 1'b0;
      prev1_q <= 1'b0;
      guard_q <= '0;
      sel_q   <= HOST0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_FILL && fill_q != FILL_LAST) fill_q <= fill_q + FW'(1);
      prev0_q <= sel0_i;
      prev1_q <= sel1_i;
      guard_q <= guard_d;
      sel_q   <= sel_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/hs_drive.sv
module hs_drive
  import host_sel_pkg::*;
(
  input  host_e            sel_i,
  input  logic             mirror_i,
  input  logic             edge_mode_i,
  input  logic [PORTS-1:0] idle_i,
  output logic [PORTS-1:0] oe_o,
  output logic             sel_stat_o,
  output logic             idle0_o
);
  logic src_idle;

  for (genvar h = 0; h < HOSTS; h++) begin : g_host
    // host transmitters always carry device receive data
    assign oe_o[h] = ~idle_i[DEV_IDX] & ((int'(sel_i) == h) | mirror_i);
  end

  assign src_idle        = (sel_i == HOST1) ? idle_i[1] : idle_i[0];
  assign oe_o[DEV_IDX]   = ~src_idle;
  assign sel_stat_o      = edge_mode_i ? (sel_i == HOST0) : idle_i[1];
  assign idle0_o         = idle_i[0];
endmodule

// File: rtl/host_sel_ctrl.sv
module host_sel_ctrl
  import host_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_mode_i,
  input  logic       mirror_i,
  input  logic       sel0_i,
  input  logic       sel1_i,
  input  logic [2:0] idle_i,
  output logic       dev_src_o,
  output logic [2:0] oe_o,
  output logic       sel_stat_o,
  output logic       idle0_o
);
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  host_e             sel;

  assign ctrl_raw[C_SEL0] = sel0_i;
  assign ctrl_raw[C_SEL1] = sel1_i;
  assign ctrl_raw[C_MIRR] = mirror_i;
  assign ctrl_raw[C_EDGE] = edge_mode_i;

  hs_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_raw),
    .q_o    (ctrl_s)
  );

  hs_select #(.SYNC_STAGES(SYNC_STAGES), .GAP_CYCLES(GAP_CYCLES)) u_select (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_mode_i (ctrl_s[C_EDGE]),
    .sel0_i      (ctrl_s[C_SEL0]),
    .sel1_i      (ctrl_s[C_SEL1]),
    .sel_o       (sel)
  );

  hs_drive u_drive (
    .sel_i       (sel),
    .mirror_i    (ctrl_s[C_MIRR]),
    .edge_mode_i (ctrl_s[C_EDGE]),
    .idle_i      (idle_i),
    .oe_o        (oe_o),
    .sel_stat_o  (sel_stat_o),
    .idle0_o     (idle0_o)
  );

  assign dev_src_o = sel;
endmodule

// File: rtl/host_sel_ctrl_chk.sv
module host_sel_ctrl_chk #(
  parameter int GAP_CYCLES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       edge_mode_i,
  input logic       mirror_i,
  input logic [2:0] idle_i,
  input logic       dev_src_o,
  input logic [2:0] oe_o,
  input logic       sel_stat_o
);
  localparam int CW = $clog2(GAP_CYCLES + 8) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [1:0]    alive_q;
  logic          prev_src_q;
  logic [CW-1:0] since_q, hi_run_q;
  logic          src_chg;

  assign src_chg = dev_src_o != prev_src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alive_q    <= '0;
      prev_src_q <= 1'b0;
      since_q    <= CMAX;
      hi_run_q   <= '0;
    end else begin
      if (alive_q != 2'd3) alive_q <= alive_q + 2'd1;
      prev_src_q <= dev_src_o;
      since_q    <= src_chg ? '0 : ((since_q == CMAX) ? CMAX : since_q + CW'(1));
      hi_run_q   <= !edge_mode_i ? '0 : ((hi_run_q == CMAX) ? CMAX : hi_run_q + CW'(1));
    end
  end

  // R5
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_chg && ({1'b0, hi_run_q} >= ({1'b0, since_q} + (CW+1)'(4))))
      |-> (since_q >= CW'(GAP_CYCLES)));

  // R8
  dev_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i[0] && idle_i[1]) |-> !oe_o[2]);

  // R8
  host_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i[2] |-> (oe_o[1:0] == 2'b00));

  // R9
  mirror_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive_q == 2'd3 && !$past(mirror_i, 2))
      |-> (dev_src_o ? !oe_o[0] : !oe_o[1]));

  // R10
  stat_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive_q == 2'd3 && $past(edge_mode_i, 2)) |-> (sel_stat_o == !dev_src_o));

  // R10
  stat_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive_q == 2'd3 && !$past(edge_mode_i, 2)) |-> (sel_stat_o == idle_i[1]));
endmodule

bind host_sel_ctrl host_sel_ctrl_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .edge_mode_i (edge_mode_i),
  .mirror_i    (mirror_i),
  .idle_i      (idle_i),
  .dev_src_o   (dev_src_o),
  .oe_o        (oe_o),
  .sel_stat_o  (sel_stat_o)
);

// File: tb/host_sel_ctrl_test.sv
module host_sel_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       edge_mode = 1'b0;
  logic       mirror = 1'b0;
  logic       sel0 = 1'b0;
  logic       sel1 = 1'b0;
  logic [2:0] idle = 3'b000;
  logic       dev_src;
  logic [2:0] oe;
  logic       sel_stat;
  logic       idle0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_sel_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .edge_mode_i (edge_mode),
    .mirror_i    (mirror),
    .sel0_i      (sel0),
    .sel1_i      (sel1),
    .idle_i      (idle),
    .dev_src_o   (dev_src),
    .oe_o        (oe),
    .sel_stat_o  (sel_stat),
    .idle0_o     (idle0)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic e, logic s0, logic s1);
    edge_mode = e; sel0 = s0; sel1 = s1; mirror = 1'b0; idle = 3'b000;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic t_reset_state();
    edge_mode = 1'b1; sel0 = 1'b0; sel1 = 1'b1; mirror = 1'b0; idle = 3'b000;
    rst_n = 1'b0;
    tick(2);
    chk("R6 reset dev_src", {3'b0, dev_src}, 4'h0);
    chk("R6 reset oe", {1'b0, oe}, 4'h5);
    rst_n = 1'b1;
    tick(2);
    chk("R6 not yet loaded", {3'b0, dev_src}, 4'h0);
    tick(1);
    chk("R6 edge (0,1) load", {3'b0, dev_src}, 4'h1);
    chk("R10 edge stat host1", {3'b0, sel_stat}, 4'h0);
  endtask

  task automatic t_powerup_table();
    for (int k = 0; k < 4; k++) begin
      do_reset(1'b1, k[0], k[1]);
      chk($sformatf("R6 edge pair %0d", k), {3'b0, dev_src},
          {3'b0, (k[1] && !k[0])});
    end
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R6 level load", {3'b0, dev_src}, 4'h1);
  endtask

  task automatic t_level_follow();
    do_reset(1'b0, 1'b0, 1'b0);
    tick(8);
    sel0 = 1'b1;
    tick(2);
    chk("R1 latency hold", {3'b0, dev_src}, 4'h0);
    tick(1);
    chk("R1 follow high", {3'b0, dev_src}, 4'h1);
    sel0 = 1'b0;
    tick(3);
    chk("R1 follow low", {3'b0, dev_src}, 4'h0);
  endtask

  task automatic t_level_hold();
    do_reset(1'b0, 1'b0, 1'b0);
    tick(8);
    sel1 = 1'b1;
    tick(1);
    sel0 = 1'b1;
    tick(5);
    chk("R2 hold with sel1 high", {3'b0, dev_src}, 4'h0);
    sel1 = 1'b0;
    tick(3);
    chk("R2 release resumes", {3'b0, dev_src}, 4'h1);
  endtask

  task automatic t_edge_select();
    do_reset(1'b1, 1'b0, 1'b0);
    tick(8);
    chk("R10 edge stat host0", {3'b0, sel_stat}, 4'h1);
    sel1 = 1'b1;
    tick(2);
    chk("R3 latency hold", {3'b0, dev_src}, 4'h0);
    tick(1);
    chk("R3 rise sel1", {3'b0, dev_src}, 4'h1);
    sel1 = 1'b0;
    tick(8);
    chk("R3 fall ignored", {3'b0, dev_src}, 4'h1);
    sel0 = 1'b1;
    tick(3);
    chk("R3 rise sel0", {3'b0, dev_src}, 4'h0);
    sel0 = 1'b0;
    tick(8);
    chk("R3 held", {3'b0, dev_src}, 4'h0);
  endtask

  task automatic t_both_rise();
    do_reset(1'b1, 1'b0, 1'b0);
    tick(8);
    sel1 = 1'b1;
    tick(3);
    chk("R4 setup host1", {3'b0, dev_src}, 4'h1);
    sel1 = 1'b0;
    tick(8);
    sel0 = 1'b1; sel1 = 1'b1;
    tick(3);
    chk("R4 tie picks host0", {3'b0, dev_src}, 4'h0);
    sel0 = 1'b0; sel1 = 1'b0;
    tick(8);
  endtask

  task automatic t_guard();
    do_reset(1'b1, 1'b0, 1'b0);
    tick(8);
    sel1 = 1'b1;
    tick(3);
    chk("R5 accepted", {3'b0, dev_src}, 4'h1);
    sel1 = 1'b0; sel0 = 1'b1;
    tick(6);
    chk("R5 edge in window ignored", {3'b0, dev_src}, 4'h1);
    sel0 = 1'b0;
    tick(6);
    sel0 = 1'b1;
    tick(3);
    chk("R5 edge after window", {3'b0, dev_src}, 4'h0);
    sel0 = 1'b0;
  endtask

  task automatic t_mode_switch();
    do_reset(1'b0, 1'b1, 1'b0);
    tick(8);
    chk("R7 level host1", {3'b0, dev_src}, 4'h1);
    edge_mode = 1'b1;
    tick(4);
    chk("R7 to edge keeps", {3'b0, dev_src}, 4'h1);
    sel0 = 1'b0;
    tick(4);
    chk("R7 edge ignores level", {3'b0, dev_src}, 4'h1);
    edge_mode = 1'b0;
    tick(3);
    chk("R7 to level adopts", {3'b0, dev_src}, 4'h0);
  endtask

  task automatic t_outputs();
    do_reset(1'b0, 1'b0, 1'b0);
    tick(8);
    idle = 3'b000; #1;
    chk("R8 R9 all live", {1'b0, oe}, 4'h5);
    chk("R11 idle0 low", {3'b0, idle0}, 4'h0);
    chk("R10 level stat low", {3'b0, sel_stat}, 4'h0);
    idle = 3'b100; #1;
    chk("R8 device idle", {1'b0, oe}, 4'h4);
    idle = 3'b001; #1;
    chk("R8 host0 idle", {1'b0, oe}, 4'h1);
    chk("R11 idle0 high", {3'b0, idle0}, 4'h1);
    idle = 3'b010; #1;
    chk("R8 host1 idle unsel", {1'b0, oe}, 4'h5);
    chk("R10 level stat idle1", {3'b0, sel_stat}, 4'h1);
    tick(1);
    idle = 3'b000;
    mirror = 1'b1;
    tick(3);
    chk("R9 mirror on", {1'b0, oe}, 4'h7);
    idle = 3'b100; #1;
    chk("R9 mirror device idle", {1'b0, oe}, 4'h4);
    tick(1);
    idle = 3'b000;
    sel0 = 1'b1;
    tick(3);
    idle = 3'b010; #1;
    chk("R8 R9 host1 selected idle", {1'b0, oe}, 4'h3);
    tick(1);
    idle = 3'b000;
    mirror = 1'b0;
    tick(3);
    chk("R9 mirror off host1 sel", {1'b0, oe}, 4'h6);
  endtask

  initial begin
    tick(1);
    t_reset_state();
    t_powerup_table();
    t_level_follow();
    t_level_hold();
    t_edge_select();
    t_both_rise();
    t_guard();
    t_mode_switch();
    t_outputs();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule